// File: doc/BRIEF.md
# Multiplexed Bus Read Cycle Controller

This block is a bus master sequencer. It runs one memory read at a time over a bus whose lower sixteen lines carry the address first and the data afterwards. After a start request it steps through a fixed series of clock states, T1, T2, T3 and T4. In T1 it drives the address and pulses an address-latch strobe. From T2 onwards it releases the shared lines and drives the read strobe and the transceiver controls. At the end of T4 it captures the returned data. A slow target holds READY low to stretch the cycle with wait states between T3 and T4. If READY stays low for more than a set number of wait states, the cycle is abandoned and an error pulse is raised.

Byte lanes are chosen by two signals: an active-low high-byte enable and address bit 0. A requester asks for either a word or a single byte. A request that arrives while a cycle is running is kept in a one-entry hold slot and starts as soon as the current cycle ends.

All controls are registered. The reset is synchronous and active high.

Top module: `mbus_read_ctrl`

## Requirements
- R1: While reset is high and after it, with no request, the outputs rest at idle: ale=0, ad_oe=0, rd_n=1, dt_r=1, den=0, bhe_n=1, done=0, err=0, rd_data=0.
- R2: A request sampled at a clock edge while the block is idle makes the next clock T1. Without wait states the cycle runs T1, T2, T3, T4 on consecutive clocks, and the result appears in the clock after T4.
- R3: In T1, and only in T1, ale and ad_oe are high for exactly one clock. During T1, ad_out carries request address bits 15:0 and addr_hi carries bits 19:16.
- R4: From T2 through T4 (including wait states), ad_oe=0, rd_n=0, dt_r=0 (receive) and den=1. In the clock after T4, rd_n=1, dt_r=1 and den=0.
- R5: bus_ready is sampled at the end of T3 and at the end of each wait state. Each low sample adds exactly one wait clock, and all bus controls stay unchanged during it.
- R6: The lane code {bhe_n, A0} is driven with A0 on ad_out[0] in T1. bhe_n=0 when the request is a word or address bit 0 is 1; otherwise bhe_n=1. The resulting codes are: 0/0 is a full word, 0/1 is the upper byte only (this includes a word at an odd address), 1/0 is the lower byte only, and 1/1 would mean no transfer.
- R7: rd_data takes ad_in at the end of T4. Lane [7:0] is kept when A0=0 and lane [15:8] is kept when bhe_n=0. A lane that is not selected reads as zero.
- R8: done is a single-clock pulse in the clock after T4, and rd_data is valid in that same clock.
- R9: If bus_ready is still low at the end of the MAX_WAIT-th wait state, the cycle ends. err pulses for one clock, done stays low, rd_data keeps its old value and the bus controls return to idle.
- R10: A request that arrives while a cycle is running is held. Its T1 follows directly after the current T4 or abort.
- R11: A request that arrives while a cycle is running and a held request is already waiting is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Start request, sampled each clock |
| req_addr | input | 20 | Read address |
| req_word | input | 1 | 1 = word, 0 = byte |
| bus_ready | input | 1 | Target ready, low inserts wait states |
| ad_in | input | 16 | Shared lines as received |
| ad_out | output | 16 | Value driven onto the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| addr_hi | output | 4 | Address bits 19:16 |
| ale | output | 1 | Address-latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| dt_r | output | 1 | Transceiver direction, 0 = receive |
| den | output | 1 | Transceiver enable, active high |
| bhe_n | output | 1 | High-byte enable, active low |
| rd_data | output | 16 | Captured read data, lane masked |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | One-clock wait-limit abort pulse |

## Verification
The data path is exercised with four kinds of access: a word at an even address, a byte at an even address, a byte at an odd address and a word at an odd address. Each returns the same kind of bus data, so a wrong lane code, a wrong mask or a swapped lane each shows up as a different wrong result. The wait-state count is varied from zero up to exactly MAX_WAIT, which separates a correct stretch from an off-by-one in where READY is sampled or in the abort limit. A target that never becomes ready checks the error path. Overlapping requests check that one request is held and a further one is ignored.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  localparam int BUS_ADDR_W = 20;
  localparam int BUS_DATA_W = 16;
  localparam int LANES      = 2;
  localparam int LANE_W     = BUS_DATA_W / LANES;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } tstate_e;

  typedef struct packed {
    logic [BUS_ADDR_W-1:0] addr;
    logic                  word;
  } rd_req_t;
endpackage

// File: rtl/mbr_hold.sv
module mbr_hold
  import mbr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    req_valid,
  input  rd_req_t req_in,
  input  logic    launch,
  output logic    hold_v,
  output rd_req_t launch_req
);
  rd_req_t hold_q;

  assign launch_req = hold_v ? hold_q : req_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v <= 1'b0;
      hold_q <= '0;
    end else if (launch && hold_v) begin
      hold_v <= req_valid;
      if (req_valid) hold_q <= req_in;
    end else if (req_valid && !launch && !hold_v) begin
      hold_v <= 1'b1;
      hold_q <= req_in;
    end
  end
endmodule

// File: rtl/mbr_fsm.sv
module mbr_fsm
  import mbr_pkg::*;
#(
  parameter int MAX_WAIT = 8,
  localparam int WAIT_W  = $clog2(MAX_WAIT + 1)
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    pending,
  input  logic    bus_ready,
  output tstate_e st_d,
  output logic    launch,
  output logic    finish_ok,
  output logic    abort
);
  tstate_e           st_q;
  logic [WAIT_W-1:0] wcnt;

  always_comb begin
    finish_ok = (st_q == ST_T4);
    abort     = (st_q == ST_TW) && !bus_ready && (wcnt == WAIT_W'(MAX_WAIT));
    launch    = ((st_q == ST_IDLE) || finish_ok || abort) && pending;
    st_d      = st_q;
    case (st_q)
      ST_IDLE: st_d = launch ? ST_T1 : ST_IDLE;
      ST_T1:   st_d = ST_T2;
      ST_T2:   st_d = ST_T3;
      ST_T3:   st_d = bus_ready ? ST_T4 : ST_TW;
      ST_TW: begin
        if (bus_ready)  st_d = ST_T4;
        else if (abort) st_d = launch ? ST_T1 : ST_IDLE;
        else            st_d = ST_TW;
      end
      ST_T4:   st_d = launch ? ST_T1 : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
      wcnt <= '0;
    end else begin
      st_q <= st_d;
      if (st_d == ST_TW) wcnt <= (st_q == ST_TW) ? wcnt + 1'b1 : WAIT_W'(1);
      else               wcnt <= '0;
    end
  end
endmodule

// File: rtl/mbr_lanes.sv
module mbr_lanes
  import mbr_pkg::*;
(
  input  rd_req_t                 req,
  input  logic [LANES-1:0]        en_q,
  input  logic [BUS_DATA_W-1:0]   bus_in,
  output logic [LANES-1:0]        en_d,
  output logic                    bhe_n_d,
  output logic [BUS_DATA_W-1:0]   masked
);
  assign en_d[0] = !req.addr[0];
  assign en_d[1] = req.word || req.addr[0];
  assign bhe_n_d = !en_d[1];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign masked[g*LANE_W +: LANE_W] = en_q[g] ? bus_in[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/mbus_read_ctrl.sv
module mbus_read_ctrl
  import mbr_pkg::*;
#(
  parameter int MAX_WAIT = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             req_valid,
  input  logic [BUS_ADDR_W-1:0]            req_addr,
  input  logic                             req_word,
  input  logic                             bus_ready,
  input  logic [BUS_DATA_W-1:0]            ad_in,
  output logic [BUS_DATA_W-1:0]            ad_out,
  output logic                             ad_oe,
  output logic [BUS_ADDR_W-BUS_DATA_W-1:0] addr_hi,
  output logic                             ale,
  output logic                             rd_n,
  output logic                             dt_r,
  output logic                             den,
  output logic                             bhe_n,
  output logic [BUS_DATA_W-1:0]            rd_data,
  output logic                             done,
  output logic                             err
);
  rd_req_t          req_in, launch_req;
  logic             hold_v, launch, finish_ok, abort, bhe_n_d, in_rx;
  tstate_e          st_d;
  logic [LANES-1:0] en_d, en_q;
  logic [BUS_DATA_W-1:0] masked;

  assign req_in = '{addr: req_addr, word: req_word};

  mbr_hold u_hold (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_in(req_in),
    .launch(launch), .hold_v(hold_v), .launch_req(launch_req)
  );

  mbr_fsm #(.MAX_WAIT(MAX_WAIT)) u_fsm (
    .clk(clk), .rst(rst), .pending(hold_v || req_valid), .bus_ready(bus_ready),
    .st_d(st_d), .launch(launch), .finish_ok(finish_ok), .abort(abort)
  );

  mbr_lanes u_lanes (
    .req(launch_req), .en_q(en_q), .bus_in(ad_in),
    .en_d(en_d), .bhe_n_d(bhe_n_d), .masked(masked)
  );

  assign in_rx = (st_d == ST_T2) || (st_d == ST_T3) || (st_d == ST_TW) || (st_d == ST_T4);

  always_ff @(posedge clk) begin
    if (rst) begin
      ale     <= 1'b0;
      ad_oe   <= 1'b0;
      rd_n    <= 1'b1;
      dt_r    <= 1'b1;
      den     <= 1'b0;
      bhe_n   <= 1'b1;
      en_q    <= '0;
      ad_out  <= '0;
      addr_hi <= '0;
      rd_data <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      ale   <= (st_d == ST_T1);
      ad_oe <= (st_d == ST_T1);
      rd_n  <= !in_rx;
      dt_r  <= !in_rx;
      den   <= in_rx;
      if (launch) begin
        ad_out  <= launch_req.addr[BUS_DATA_W-1:0];
        addr_hi <= launch_req.addr[BUS_ADDR_W-1:BUS_DATA_W];
        bhe_n   <= bhe_n_d;
        en_q    <= en_d;
      end
      done <= finish_ok;
      err  <= abort;
      if (finish_ok) rd_data <= masked;
    end
  end
endmodule

// File: rtl/mbus_read_ctrl_chk.sv
module mbus_read_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic ale,
  input logic ad_oe,
  input logic rd_n,
  input logic dt_r,
  input logic den,
  input logic bhe_n,
  input logic done,
  input logic err
);
  assert_ale_single_R3: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);
  assert_ale_drives_addr_R3: assert property (@(posedge clk) disable iff (rst)
    ale |-> (ad_oe && rd_n));
  assert_receive_ctrl_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> (den && !dt_r && !ad_oe && !ale));
  assert_lane_steady_R5: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> $stable(bhe_n));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_bus_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> rd_n);
  assert_err_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  assert_err_bus_idle_R9: assert property (@(posedge clk) disable iff (rst)
    err |-> (rd_n && !den));
endmodule

bind mbus_read_ctrl mbus_read_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .ale(ale), .ad_oe(ad_oe), .rd_n(rd_n), .dt_r(dt_r),
  .den(den), .bhe_n(bhe_n), .done(done), .err(err)
);

// File: tb/mbus_read_ctrl_tb.sv
module mbus_read_ctrl_tb;
  localparam int MAXW = 8;
  localparam int NV   = 8;

  localparam logic [19:0] V_ADDR [NV] = '{20'hA1230, 20'h0F00E, 20'h55551, 20'hFFFFF,
                                          20'h00000, 20'h80002, 20'h12347, 20'h3C3C4};
  localparam logic        V_WORD [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam int          V_WAIT [NV] = '{0, 1, 2, 0, 3, MAXW, 0, 5};
  localparam logic [15:0] V_DIN  [NV] = '{16'hBEEF, 16'h1234, 16'hABCD, 16'h5A5A,
                                          16'hC3C3, 16'h7788, 16'hFFFF, 16'h9966};
  localparam logic        V_BHE  [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [15:0] V_EXP  [NV] = '{16'hBEEF, 16'h0034, 16'hAB00, 16'h5A00,
                                          16'hC3C3, 16'h0088, 16'hFF00, 16'h0066};

  logic clk = 1'b0, rst = 1'b1, req_valid = 1'b0, req_word = 1'b0, bus_ready = 1'b1;
  logic [19:0] req_addr = '0;
  logic [15:0] ad_in = '0;
  logic [15:0] ad_out, rd_data;
  logic [3:0]  addr_hi;
  logic ad_oe, ale, rd_n, dt_r, den, bhe_n, done, err;
  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mbus_read_ctrl #(.MAX_WAIT(MAXW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_word(req_word),
    .bus_ready(bus_ready), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi),
    .ale(ale), .rd_n(rd_n), .dt_r(dt_r), .den(den), .bhe_n(bhe_n), .rd_data(rd_data),
    .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ctl_is(input string tag, input logic [4:0] exp);
    chk({ale, ad_oe, rd_n, dt_r, den} === exp, tag, {27'd0, ale, ad_oe, rd_n, dt_r, den}, {27'd0, exp});
  endtask

  task automatic send(input logic [19:0] a, input logic w);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_word = w;
  endtask

  // one full read, request issued at the next negedge
  task automatic run_read(input logic [19:0] a, input logic w, input int waits,
                          input logic [15:0] din, input logic bexp, input logic [15:0] dexp);
    bus_ready = (waits == 0);
    send(a, w);
    @(negedge clk); req_valid = 1'b0;                       // T1
    ctl_is("R3 T1 controls", 5'b11110);
    chk(ad_out === a[15:0], "R3 T1 address low", ad_out, a[15:0]);
    chk(addr_hi === a[19:16], "R3 T1 address high", addr_hi, a[19:16]);
    chk({bhe_n, ad_out[0]} === {bexp, a[0]}, "R6 lane code", {bhe_n, ad_out[0]}, {bexp, a[0]});
    @(negedge clk); ad_in = din;                            // T2
    ctl_is("R4 T2 controls", 5'b00001);
    @(negedge clk);                                         // T3
    ctl_is("R4 T3 controls", 5'b00001);
    for (int k = 0; k < waits; k++) begin
      @(negedge clk);                                       // wait state
      ctl_is("R5 wait state held", 5'b00001);
      chk(!done && !err, "R5 no early completion", {done, err}, 0);
      if (k == waits - 1) bus_ready = 1'b1;
    end
    @(negedge clk);                                         // T4
    ctl_is("R4 T4 controls", 5'b00001);
    chk(done === 1'b0, "R2 no done in T4", done, 0);
    @(negedge clk);                                         // after T4
    chk(done === 1'b1 && err === 1'b0, "R8 done pulse", {done, err}, 2'b10);
    chk(rd_data === dexp, "R7 read data", rd_data, dexp);
    ctl_is("R4 bus released", 5'b00110);
    @(negedge clk);
    chk(done === 1'b0, "R8 done one clock", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    ctl_is("R1 reset controls", 5'b00110);
    chk({bhe_n, done, err} === 3'b100, "R1 reset flags", {bhe_n, done, err}, 3'b100);
    chk(rd_data === 16'h0, "R1 reset data", rd_data, 0);
    rst = 1'b0;
    @(negedge clk);
    ctl_is("R1 idle after reset", 5'b00110);

    for (int i = 0; i < NV; i++)
      run_read(V_ADDR[i], V_WORD[i], V_WAIT[i], V_DIN[i], V_BHE[i], V_EXP[i]);

    // R9: target never ready
    bus_ready = 1'b0;
    send(20'h22220, 1'b1);
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    for (int k = 0; k < MAXW; k++) begin
      @(negedge clk);
      chk(rd_n === 1'b0 && err === 1'b0, "R9 waiting before limit", {rd_n, err}, 0);
    end
    @(negedge clk);
    chk(err === 1'b1 && done === 1'b0, "R9 abort pulse", {err, done}, 2'b10);
    chk(rd_data === 16'h0066, "R9 data kept", rd_data, 16'h0066);
    ctl_is("R9 bus idle on abort", 5'b00110);
    @(negedge clk);
    chk(err === 1'b0, "R9 err one clock", err, 0);

    // R10 / R11: held request then ignored request
    bus_ready = 1'b1; ad_in = 16'h1122;
    send(20'h01230, 1'b1);
    @(negedge clk); req_addr = 20'h04561; req_word = 1'b0;          // A T1, B requested
    @(negedge clk); req_addr = 20'h07770; req_word = 1'b1;          // A T2, C requested
    @(negedge clk); req_valid = 1'b0;                               // A T3
    @(negedge clk);                                                 // A T4
    @(negedge clk);
    chk(done === 1'b1 && rd_data === 16'h1122, "R10 first read done", rd_data, 16'h1122);
    chk(ale === 1'b1 && ad_out === 16'h4561, "R10 held request starts", ad_out, 16'h4561);
    @(negedge clk); @(negedge clk); @(negedge clk);
    @(negedge clk);
    chk(done === 1'b1 && rd_data === 16'h1100, "R10 held read data", rd_data, 16'h1100);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(ale === 1'b0 && rd_n === 1'b1, "R11 extra request ignored", {ale, rd_n}, 2'b01);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule